// File: doc/BRIEF.md
# Horner Polynomial Micro-op Sequencer

This block turns one polynomial-evaluation instruction into a short run of micro-ops that evaluate the polynomial by Horner's method. The instruction supplies a destination register, a register holding the argument x, a base register where the coefficients start, and an immediate that holds the degree and a chaining flag. The block takes the instruction through a start/ready handshake. It then issues micro-ops one at a time to a downstream valid/ready port. Each micro-op is either a move or a fused multiply-add, dest = dest*x + coef, and it names its destination, its multiplier source and its addend source.

A fresh evaluation first copies the highest coefficient into the destination. Each multiply-add after that folds in the next lower coefficient, until the coefficient at the base register has been used. One instruction is limited to degree seven. To go higher, the instruction is chained: with the chaining flag set, the destination already holds the partial result. Only multiply-adds are issued, and they use the coefficients just below base+degree, so a chained degree-7 instruction adds seven more terms. Encodings that are out of range are reported on a one-cycle illegal-instruction flag, and nothing is issued for them.

Top module: `hzp_poly_seq`

## Requirements
- R1: After reset, start_ready is 1, uop_valid is 0 and illegal is 0.
- R2: With imm[6]=0 and degree d=imm[5:0] no greater than 7, the first micro-op is a move (uop_op=0) with uop_src_add=base+d, uop_dst=dst and uop_src_x=x.
- R3: After the move of R2, exactly d fused multiply-adds (uop_op=1) follow, with uop_src_add taking the values base+d-1 down to base, each one lower than the one before it.
- R4: With imm[6]=1 and d from 1 to 7, exactly d fused multiply-adds are issued with uop_src_add from base+d-1 down to base, and no move is issued.
- R5: With imm[6]=1 and d=0, no micro-op is issued, illegal stays 0 and start_ready stays 1, so a new instruction can be accepted in the next cycle.
- R6: A degree field imm[5:0] greater than 7 sets illegal for exactly one cycle, the cycle after acceptance, and no micro-op is issued.
- R7: If the highest coefficient index the instruction would use (base+d, or base+d-1 when chained) is above 127, illegal is set as in R6 and no micro-op is issued. A chained instruction with d=0 never counts as out of range.
- R8: A micro-op is issued in a cycle only when uop_valid and uop_ready are both 1. While uop_ready is 0, uop_valid and every micro-op field hold their values.
- R9: start_ready is 0 from the cycle after a legal, non-empty instruction is accepted until the cycle after its final micro-op is accepted, when it returns to 1 and uop_valid returns to 0.
- R10: uop_last is 1 on the final micro-op of an instruction and 0 on all the others.
- R11: One instruction never issues more than 16 micro-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Instruction is offered |
| start_ready | output | 1 | Sequencer can accept an instruction |
| inst_dst | input | 7 | Destination / accumulator register |
| inst_x | input | 7 | Register holding the argument x |
| inst_base | input | 7 | First coefficient register |
| inst_imm | input | 8 | [5:0] degree, [6] chaining flag, [7] unused |
| illegal | output | 1 | One-cycle pulse for an illegal encoding |
| uop_valid | output | 1 | Micro-op is presented |
| uop_ready | input | 1 | Downstream takes the micro-op |
| uop_op | output | 1 | 0 = move, 1 = fused multiply-add |
| uop_dst | output | 7 | Micro-op destination register |
| uop_src_x | output | 7 | Multiplier source (x) |
| uop_src_add | output | 7 | Coefficient (addend) register |
| uop_last | output | 1 | Final micro-op of the instruction |

## Verification
On every cycle the assertions check the following: start is blocked while a micro-op is pending; the fields hold under a stall; each accepted non-final micro-op is followed by a multiply-add whose coefficient index is one lower; the illegal pulse never comes with a valid micro-op; the per-instruction budget holds; and the block returns to idle after the final handshake. Only the bench scenarios can show the exact coefficient sequence, for every degree in both fresh and chained modes. They also show the move at the start, the position of the final-micro-op marker, the empty chained degree-0 case, and the legality boundary near register 127 under bursty downstream readiness.

// File: rtl/hzp_pkg.sv
package hzp_pkg;
   typedef enum logic {
      UOP_MOVE = 1'b0,
      UOP_FMA  = 1'b1
   } uop_op_e;
endpackage

// File: rtl/hzp_decode.sv
module hzp_decode #(
   parameter int NUM_REGS    = 128,
   parameter int REG_W       = 7,
   parameter int IMM_W       = 8,
   parameter int DEG_FIELD_W = 6,
   parameter int CONT_BIT    = 6,
   parameter int MAX_DEG     = 7
) (
   input  logic [REG_W-1:0] base_i,
   input  logic [IMM_W-1:0] imm_i,
   output logic             illegal_o,
   output logic             empty_o,
   output logic             is_move_o,
   output logic [REG_W-1:0] start_idx_o
);
   localparam int EXT_W = REG_W + 1;

   logic [DEG_FIELD_W-1:0] deg;
   logic                   cont;
   logic [EXT_W-1:0]       top_ext;
   logic                   over;
   logic                   bad_deg;

   assign deg     = imm_i[DEG_FIELD_W-1:0];
   assign cont    = imm_i[CONT_BIT];
   assign top_ext = {1'b0, base_i} + EXT_W'(deg) - EXT_W'(cont);
   assign bad_deg = (int'(deg) > MAX_DEG);

   generate
      if (NUM_REGS == (1 << REG_W)) begin : g_pow2_bound
         assign over = top_ext[REG_W];
      end else begin : g_cmp_bound
         assign over = (int'(top_ext) >= NUM_REGS);
      end
   endgenerate

   assign empty_o     = cont && (deg == '0);
   assign illegal_o   = bad_deg || (!empty_o && over);
   assign is_move_o   = !cont;
   assign start_idx_o = top_ext[REG_W-1:0];
endmodule

// File: rtl/hzp_seq.sv
module hzp_seq #(
   parameter int REG_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [REG_W-1:0] start_idx_i,
   input  logic [REG_W-1:0] base_i,
   input  logic [REG_W-1:0] dst_i,
   input  logic [REG_W-1:0] x_i,
   input  logic             is_move_i,
   input  logic             fire_i,
   output logic             busy_o,
   output logic             mv_o,
   output logic             last_o,
   output logic [REG_W-1:0] idx_o,
   output logic [REG_W-1:0] dst_o,
   output logic [REG_W-1:0] x_o
);
   logic [REG_W-1:0] base_q;

   assign last_o = (idx_o == base_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         mv_o   <= 1'b0;
         idx_o  <= '0;
         base_q <= '0;
         dst_o  <= '0;
         x_o    <= '0;
      end else if (load_i) begin
         busy_o <= 1'b1;
         mv_o   <= is_move_i;
         idx_o  <= start_idx_i;
         base_q <= base_i;
         dst_o  <= dst_i;
         x_o    <= x_i;
      end else if (fire_i) begin
         mv_o <= 1'b0;
         if (last_o) begin
            busy_o <= 1'b0;
         end else begin
            idx_o <= idx_o - 1'b1;
         end
      end
   end
endmodule

// File: rtl/hzp_emit.sv
module hzp_emit #(
   parameter int REG_W = 7
) (
   input  logic             busy_i,
   input  logic             mv_i,
   input  logic             last_i,
   input  logic [REG_W-1:0] idx_i,
   input  logic [REG_W-1:0] dst_i,
   input  logic [REG_W-1:0] x_i,
   output logic             valid_o,
   output logic             op_o,
   output logic             last_o,
   output logic [REG_W-1:0] dst_o,
   output logic [REG_W-1:0] src_x_o,
   output logic [REG_W-1:0] src_add_o
);
   import hzp_pkg::*;

   uop_op_e op_sel;

   always_comb begin
      op_sel = mv_i ? UOP_MOVE : UOP_FMA;
   end

   assign valid_o   = busy_i;
   assign op_o      = op_sel;
   assign last_o    = busy_i && last_i;
   assign dst_o     = dst_i;
   assign src_x_o   = x_i;
   assign src_add_o = idx_i;
endmodule

// File: rtl/hzp_poly_seq.sv
module hzp_poly_seq #(
   parameter int NUM_REGS    = 128,
   parameter int REG_W       = $clog2(NUM_REGS),
   parameter int IMM_W       = 8,
   parameter int DEG_FIELD_W = 6,
   parameter int CONT_BIT    = 6,
   parameter int MAX_DEG     = 7,
   parameter int MAX_UOPS    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_valid,
   output logic             start_ready,
   input  logic [REG_W-1:0] inst_dst,
   input  logic [REG_W-1:0] inst_x,
   input  logic [REG_W-1:0] inst_base,
   input  logic [IMM_W-1:0] inst_imm,
   output logic             illegal,
   output logic             uop_valid,
   input  logic             uop_ready,
   output logic             uop_op,
   output logic [REG_W-1:0] uop_dst,
   output logic [REG_W-1:0] uop_src_x,
   output logic [REG_W-1:0] uop_src_add,
   output logic             uop_last
);
   generate
      if (MAX_DEG + 1 > MAX_UOPS) begin : g_bad_budget
         $error("hzp_poly_seq: MAX_DEG+1 exceeds MAX_UOPS");
      end
      if (CONT_BIT >= IMM_W || DEG_FIELD_W > CONT_BIT) begin : g_bad_imm
         $error("hzp_poly_seq: immediate field layout invalid");
      end
      if ((1 << DEG_FIELD_W) <= MAX_DEG) begin : g_bad_deg
         $error("hzp_poly_seq: degree field too narrow");
      end
      if (NUM_REGS > (1 << REG_W)) begin : g_bad_regs
         $error("hzp_poly_seq: REG_W too small");
      end
   endgenerate

   logic             dec_illegal;
   logic             dec_empty;
   logic             dec_move;
   logic [REG_W-1:0] dec_idx;
   logic             accept;
   logic             load;
   logic             fire;
   logic             s_busy;
   logic             s_mv;
   logic             s_last;
   logic [REG_W-1:0] s_idx;
   logic [REG_W-1:0] s_dst;
   logic [REG_W-1:0] s_x;
   logic             illegal_q;

   hzp_decode #(
      .NUM_REGS(NUM_REGS), .REG_W(REG_W), .IMM_W(IMM_W),
      .DEG_FIELD_W(DEG_FIELD_W), .CONT_BIT(CONT_BIT), .MAX_DEG(MAX_DEG)
   ) u_dec (
      .base_i(inst_base), .imm_i(inst_imm),
      .illegal_o(dec_illegal), .empty_o(dec_empty),
      .is_move_o(dec_move), .start_idx_o(dec_idx)
   );

   assign start_ready = !s_busy;
   assign accept      = start_valid && start_ready;
   assign load        = accept && !dec_illegal && !dec_empty;
   assign fire        = uop_valid && uop_ready;

   hzp_seq #(.REG_W(REG_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .load_i(load), .start_idx_i(dec_idx),
      .base_i(inst_base), .dst_i(inst_dst), .x_i(inst_x),
      .is_move_i(dec_move), .fire_i(fire),
      .busy_o(s_busy), .mv_o(s_mv), .last_o(s_last),
      .idx_o(s_idx), .dst_o(s_dst), .x_o(s_x)
   );

   hzp_emit #(.REG_W(REG_W)) u_emit (
      .busy_i(s_busy), .mv_i(s_mv), .last_i(s_last), .idx_i(s_idx),
      .dst_i(s_dst), .x_i(s_x),
      .valid_o(uop_valid), .op_o(uop_op), .last_o(uop_last),
      .dst_o(uop_dst), .src_x_o(uop_src_x), .src_add_o(uop_src_add)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         illegal_q <= 1'b0;
      end else begin
         illegal_q <= accept && dec_illegal;
      end
   end

   assign illegal = illegal_q;
endmodule

// File: rtl/hzp_poly_seq_chk.sv
module hzp_poly_seq_chk #(
   parameter int REG_W    = 7,
   parameter int MAX_UOPS = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_ready,
   input logic             illegal,
   input logic             uop_valid,
   input logic             uop_ready,
   input logic             uop_op,
   input logic [REG_W-1:0] uop_dst,
   input logic [REG_W-1:0] uop_src_add,
   input logic             uop_last
);
   int emitted;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         emitted <= 0;
      end else if (uop_valid && uop_ready) begin
         emitted <= uop_last ? 0 : emitted + 1;
      end
   end

   p_start_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      uop_valid |-> !start_ready);

   p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_op) &&
         $stable(uop_dst) && $stable(uop_src_add) && $stable(uop_last)));

   p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && uop_ready && !uop_last) |=>
         (uop_valid && uop_op == 1'b1 && uop_src_add == $past(uop_src_add) - 1'b1));

   p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !uop_valid);

   p_budget_r11: assert property (@(posedge clk) disable iff (!rst_n)
      uop_valid |-> (emitted < MAX_UOPS));

   p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && uop_ready && uop_last) |=> (start_ready && !uop_valid));
endmodule

bind hzp_poly_seq hzp_poly_seq_chk #(.REG_W(REG_W), .MAX_UOPS(MAX_UOPS)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_ready(start_ready), .illegal(illegal),
   .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op),
   .uop_dst(uop_dst), .uop_src_add(uop_src_add), .uop_last(uop_last)
);

// File: tb/hzp_poly_seq_test.sv
module hzp_poly_seq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_valid = 1'b0;
   logic       start_ready;
   logic [6:0] inst_dst = '0;
   logic [6:0] inst_x = '0;
   logic [6:0] inst_base = '0;
   logic [7:0] inst_imm = '0;
   logic       illegal;
   logic       uop_valid;
   logic       uop_ready = 1'b0;
   logic       uop_op;
   logic [6:0] uop_dst;
   logic [6:0] uop_src_x;
   logic [6:0] uop_src_add;
   logic       uop_last;

   int vectors = 0;
   int fails = 0;
   int cyc = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   hzp_poly_seq uut (
      .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
      .inst_dst(inst_dst), .inst_x(inst_x), .inst_base(inst_base), .inst_imm(inst_imm),
      .illegal(illegal), .uop_valid(uop_valid), .uop_ready(uop_ready),
      .uop_op(uop_op), .uop_dst(uop_dst), .uop_src_x(uop_src_x),
      .uop_src_add(uop_src_add), .uop_last(uop_last)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_inst(input int cont, input int deg, input int base, input int pat);
      int  dst;
      int  xr;
      int  top;
      int  cnt;
      bit  legal;
      int  n;
      int  guard;
      int  eop;
      int  eidx;
      bit  r;
      dst   = (base * 3 + deg + 11) % 128;
      xr    = (base + 5 + cont) % 128;
      top   = base + deg - cont;
      cnt   = cont ? deg : deg + 1;
      legal = (deg <= 7) && ((cont && deg == 0) || top <= 127);
      chk(start_ready == 1'b1, "R9 idle before start", int'(start_ready), 1);
      start_valid = 1'b1;
      inst_dst    = dst[6:0];
      inst_x      = xr[6:0];
      inst_base   = base[6:0];
      inst_imm    = {1'b0, cont[0], deg[5:0]};
      @(negedge clk);
      start_valid = 1'b0;
      if (deg > 7)
         chk(illegal == 1'b1, "R6 degree field illegal", int'(illegal), 1);
      else
         chk(illegal == !legal, legal ? "R7 legal index" : "R7 index overflow",
             int'(illegal), int'(!legal));
      if (!legal || cnt == 0) begin
         chk(uop_valid == 1'b0, legal ? "R5 empty chain no uop" : "R6 no uop on illegal",
             int'(uop_valid), 0);
         chk(start_ready == 1'b1, legal ? "R5 ready stays high" : "R6 ready after illegal",
             int'(start_ready), 1);
         @(negedge clk);
         chk(illegal == 1'b0, "R6 illegal single pulse", int'(illegal), 0);
         return;
      end
      n = 0;
      guard = 0;
      while (n < cnt && guard < 200) begin
         guard++;
         if (cont) begin
            eop  = 1;
            eidx = base + deg - 1 - n;
         end else begin
            eop  = (n == 0) ? 0 : 1;
            eidx = base + deg - n;
         end
         chk(uop_valid == 1'b1, "R8 uop presented", int'(uop_valid), 1);
         chk(int'(uop_op) == eop, cont ? "R4 chained op" : (n == 0 ? "R2 move first" : "R3 fma op"),
             int'(uop_op), eop);
         chk(int'(uop_src_add) == eidx, cont ? "R4 coef index" : (n == 0 ? "R2 top coef" : "R3 coef index"),
             int'(uop_src_add), eidx);
         chk(int'(uop_dst) == dst, "R2 destination", int'(uop_dst), dst);
         chk(int'(uop_src_x) == xr, "R2 x source", int'(uop_src_x), xr);
         chk(uop_last == (n == cnt - 1), "R10 last marker", int'(uop_last), int'(n == cnt - 1));
         chk(start_ready == 1'b0, "R9 busy blocks start", int'(start_ready), 0);
         r = (pat == 0) ? 1'b1 : ((cyc % 3) != 1);
         uop_ready = r;
         @(negedge clk);
         if (r) n++;
      end
      uop_ready = 1'b0;
      chk(n == cnt && n <= 16, "R11 uop count", n, cnt);
      chk(uop_valid == 1'b0, "R9 valid drops after last", int'(uop_valid), 0);
      chk(start_ready == 1'b1, "R9 ready after last", int'(start_ready), 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int bases[6];
      bases[0] = 0; bases[1] = 9; bases[2] = 64;
      bases[3] = 120; bases[4] = 126; bases[5] = 127;
      repeat (3) @(negedge clk);
      chk(start_ready == 1'b1, "R1 reset start_ready", int'(start_ready), 1);
      chk(uop_valid == 1'b0, "R1 reset uop_valid", int'(uop_valid), 0);
      chk(illegal == 1'b0, "R1 reset illegal", int'(illegal), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int p = 0; p < 2; p++)
         for (int b = 0; b < 6; b++)
            for (int c = 0; c < 2; c++)
               for (int d = 0; d < 10; d++)
                  run_inst(c, d, bases[b], p);
      run_inst(0, 63, 0, 1);
      run_inst(1, 40, 3, 0);
      run_inst(1, 0, 127, 0);
      run_inst(0, 7, 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule